// File: doc/BRIEF.md
# Octal-Wrapping Indirect Scratchpad

This block is a 64-entry, 8-bit register file for a small processor datapath. Any entry can be reached through a 6-bit indirect pointer. The first sixteen entries can also be reached by a 4-bit direct register number. The pointer is treated as two 3-bit octal digits.

An indirect access can leave the pointer alone, step it up or step it down after the access. Stepping touches only the low digit, so a walk through the file circles inside one aligned group of eight entries and never moves to the next group. Each digit can be loaded on its own from a 3-bit immediate.

A separate port saves a status byte into entry 9 in one cycle. Entry 9 is always visible on its own output, so the status byte can be restored in one step. The read port is combinational and shows the contents of the addressed entry as they were before the current cycle's write.

Top module: `spad_octal_ptr`

## Requirements
- R1: After reset every entry holds 0x00, the pointer reads 0o00 and the status-slot output reads 0x00.
- R2: With `acc_mode_i` = 2'b00 (direct), `acc_dir_i` selects entry 0..15. A write with `acc_en_i` and `acc_we_i` high is stored at the clock edge.
- R3: With `acc_mode_i` = 2'b01 (indirect, hold), the access targets the entry named by the pointer, and the pointer does not change.
- R4: With `acc_mode_i` = 2'b10 (indirect, step up), the low digit (bits 2:0) rises by one modulo 8 after the access, and the high digit (bits 5:3) keeps its value. For example 0o26 becomes 0o27, and 0o27 becomes 0o20.
- R5: With `acc_mode_i` = 2'b11 (indirect, step down), the low digit falls by one modulo 8 after the access, and the high digit keeps its value. For example 0o21 becomes 0o20, and 0o20 becomes 0o27.
- R6: A direct access never reaches entries 16..63. Those entries are reachable only through the pointer.
- R7: `ptr_hi_ld_i` loads `ptr_imm_i` into bits 5:3 and `ptr_lo_ld_i` loads it into bits 2:0. Each load is independent of the other, and a load of a digit overrides a step of that same digit in the same cycle.
- R8: During a write access, `rdata_o` shows the entry's old contents. The new contents and any pointer step become visible only after the clock edge.
- R9: `stat_save_i` stores `stat_i` into entry 9 at the clock edge. `stat_slot_o` always shows the current contents of entry 9.
- R10: When a status save and a general write to entry 9 happen in the same cycle, the saved status byte is the one kept.
- R11: With `acc_en_i` low, no entry is written and the pointer does not step, whatever the other access inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_en_i | input | 1 | Access enable (allows the write and the pointer step) |
| acc_we_i | input | 1 | Write select for the access |
| acc_mode_i | input | 2 | 00 direct, 01 indirect hold, 10 indirect step up, 11 indirect step down |
| acc_dir_i | input | 4 | Direct entry number |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Contents of the addressed entry |
| ptr_hi_ld_i | input | 1 | Load the high pointer digit |
| ptr_lo_ld_i | input | 1 | Load the low pointer digit |
| ptr_imm_i | input | 3 | Digit immediate |
| ptr_o | output | 6 | Current pointer |
| stat_save_i | input | 1 | Save the status byte into entry 9 |
| stat_i | input | 8 | Status byte to save |
| stat_slot_o | output | 8 | Contents of entry 9 |

## Verification
The pointer checks assume that a digit load and a step can be requested in the same cycle, and that the mode code is always one of the four defined values. The stimulus drives only those codes, and it includes cycles where a load and a step collide.

The status-slot check assumes that a save may overlap any general write. The bench deliberately overlaps a save with a direct write to entry 9.

Inputs change only one time unit after a rising edge, so every input is stable at the edge where the properties sample it.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_IND_HOLD = 2'b01,
    AM_IND_INC  = 2'b10,
    AM_IND_DEC  = 2'b11
  } acc_mode_e;
endpackage

// File: rtl/spad_ptr.sv
module spad_ptr #(
  parameter int DIGIT_W = 3,
  localparam int PTR_W  = 2 * DIGIT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               down_i,
  input  logic               hi_ld_i,
  input  logic               lo_ld_i,
  input  logic [DIGIT_W-1:0] imm_i,
  output logic [PTR_W-1:0]   ptr_o
);
  localparam logic [DIGIT_W-1:0] ONE = DIGIT_W'(1);

  logic [DIGIT_W-1:0] hi_q, lo_q, lo_next;

  // low digit wraps inside its own width; no carry into hi
  always_comb lo_next = down_i ? (lo_q - ONE) : (lo_q + ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_ld_i) hi_q <= imm_i;
      if (lo_ld_i)     lo_q <= imm_i;
      else if (step_i) lo_q <= lo_next;
    end
  end

  assign ptr_o = {hi_q, lo_q};

  // R4
  hi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !hi_ld_i) |=> $stable(hi_q));
  // R4
  lo_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !down_i && !lo_ld_i) |=> (lo_q == DIGIT_W'($past(lo_q) + ONE)));
  // R5
  lo_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && down_i && !lo_ld_i) |=> (lo_q == DIGIT_W'($past(lo_q) - ONE)));
  // R7
  lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_ld_i |=> (lo_q == $past(imm_i)));
endmodule

// File: rtl/spad_bank.sv
module spad_bank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int SLOT   = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sv_en_i,
  input  logic [DATA_W-1:0] sv_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] slot_o
);
  logic [DATA_W-1:0] mem_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DATA_W-1:0] q;
    logic              gen_hit;
    assign gen_hit = wr_en_i && (addr_i == ADDR_W'(i));
    if (i == SLOT) begin : g_slot
      // save port wins over the general write
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (sv_en_i) q <= sv_data_i;
        else if (gen_hit) q <= wdata_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (gen_hit) q <= wdata_i;
      end
    end
    assign mem_w[i] = q;
  end

  assign rdata_o = mem_w[addr_i];
  assign slot_o  = mem_w[SLOT];

  // R10
  save_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sv_en_i |=> (slot_o == $past(sv_data_i)));
endmodule

// File: rtl/spad_octal_ptr.sv
module spad_octal_ptr #(
  parameter int DATA_W  = 8,
  parameter int DIGIT_W = 3,
  parameter int DIR_W   = 4,
  parameter int SLOT    = 9,
  localparam int PTR_W  = 2 * DIGIT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_en_i,
  input  logic               acc_we_i,
  input  logic [1:0]         acc_mode_i,
  input  logic [DIR_W-1:0]   acc_dir_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               ptr_hi_ld_i,
  input  logic               ptr_lo_ld_i,
  input  logic [DIGIT_W-1:0] ptr_imm_i,
  output logic [PTR_W-1:0]   ptr_o,
  input  logic               stat_save_i,
  input  logic [DATA_W-1:0]  stat_i,
  output logic [DATA_W-1:0]  stat_slot_o
);
  import spad_pkg::*;

  acc_mode_e        mode;
  logic             ind, step, down;
  logic [PTR_W-1:0] addr;

  assign mode = acc_mode_e'(acc_mode_i);
  assign ind  = (mode != AM_DIRECT);
  assign step = acc_en_i && ((mode == AM_IND_INC) || (mode == AM_IND_DEC));
  assign down = (mode == AM_IND_DEC);
  assign addr = ind ? ptr_o : {{(PTR_W-DIR_W){1'b0}}, acc_dir_i};

  spad_ptr #(.DIGIT_W(DIGIT_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .down_i  (down),
    .hi_ld_i (ptr_hi_ld_i),
    .lo_ld_i (ptr_lo_ld_i),
    .imm_i   (ptr_imm_i),
    .ptr_o   (ptr_o)
  );

  spad_bank #(.DATA_W(DATA_W), .ADDR_W(PTR_W), .SLOT(SLOT)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (acc_en_i && acc_we_i),
    .addr_i    (addr),
    .wdata_i   (wdata_i),
    .sv_en_i   (stat_save_i),
    .sv_data_i (stat_i),
    .rdata_o   (rdata_o),
    .slot_o    (stat_slot_o)
  );

  // R11
  idle_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && !ptr_hi_ld_i && !ptr_lo_ld_i) |=> $stable(ptr_o));
  // R3
  hold_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_mode_i == 2'b01 && !ptr_hi_ld_i && !ptr_lo_ld_i) |=> $stable(ptr_o));
endmodule

// File: tb/sim_spad_octal_ptr.sv
module sim_spad_octal_ptr;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_en_i = 1'b0, acc_we_i = 1'b0;
  logic [1:0] acc_mode_i = 2'b00;
  logic [3:0] acc_dir_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ptr_hi_ld_i = 1'b0, ptr_lo_ld_i = 1'b0;
  logic [2:0] ptr_imm_i = '0;
  logic [5:0] ptr_o;
  logic       stat_save_i = 1'b0;
  logic [7:0] stat_i = '0;
  logic [7:0] stat_slot_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  spad_octal_ptr u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    acc_en_i = 0; acc_we_i = 0; ptr_hi_ld_i = 0; ptr_lo_ld_i = 0; stat_save_i = 0;
  endtask

  task automatic acc(input logic [1:0] m, input logic we, input logic [3:0] d, input logic [7:0] v);
    acc_en_i = 1; acc_we_i = we; acc_mode_i = m; acc_dir_i = d; wdata_i = v;
    tick(); idle();
  endtask

  task automatic set_ptr(input logic [5:0] p);
    ptr_hi_ld_i = 1; ptr_imm_i = p[5:3]; tick(); idle();
    ptr_lo_ld_i = 1; ptr_imm_i = p[2:0]; tick(); idle();
  endtask

  task automatic peek_ind(input logic [5:0] p, output logic [7:0] v);
    set_ptr(p); acc_mode_i = 2'b01; #1; v = rdata_o;
  endtask

  task automatic peek_dir(input logic [3:0] a, output logic [7:0] v);
    acc_mode_i = 2'b00; acc_dir_i = a; #1; v = rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 ptr", ptr_o, 0);
    chk("R1 slot", stat_slot_o, 0);
    peek_dir(4'd5, v); chk("R1 entry5", v, 0);
  endtask

  task automatic t_direct();
    logic [7:0] v;
    acc(2'b00, 1, 4'd3, 8'hA5);
    peek_dir(4'd3, v); chk("R2 entry3", v, 8'hA5);
    acc(2'b00, 1, 4'd15, 8'h3C);
    peek_dir(4'd15, v); chk("R2 entry15", v, 8'h3C);
    peek_ind(6'd15, v); chk("R2 entry15 via ptr", v, 8'h3C);
  endtask

  task automatic t_alias();
    logic [7:0] v;
    acc(2'b00, 1, 4'd0, 8'hEE);
    peek_ind(6'd32, v); chk("R6 entry32", v, 0);
    peek_ind(6'd48, v); chk("R6 entry48", v, 0);
    peek_ind(6'd0, v);  chk("R6 entry0", v, 8'hEE);
  endtask

  task automatic t_ptr_load();
    ptr_hi_ld_i = 1; ptr_imm_i = 3'd5; tick(); idle();
    chk("R7 hi only", ptr_o, 6'o50);
    ptr_lo_ld_i = 1; ptr_imm_i = 3'd2; tick(); idle();
    chk("R7 lo only", ptr_o, 6'o52);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    set_ptr(6'o52);
    acc(2'b01, 1, 4'd0, 8'h77);
    chk("R3 ptr kept", ptr_o, 6'o52);
    acc_mode_i = 2'b01; #1; chk("R3 data", rdata_o, 8'h77);
    peek_ind(6'o53, v); chk("R3 neighbour", v, 0);
  endtask

  task automatic t_inc_wrap();
    logic [7:0] v;
    set_ptr(6'o26);
    acc(2'b10, 1, 4'd0, 8'h11);
    chk("R4 step", ptr_o, 6'o27);
    acc(2'b10, 1, 4'd0, 8'h12);
    chk("R4 wrap 27->20", ptr_o, 6'o20);
    peek_ind(6'o27, v); chk("R4 data at 27", v, 8'h12);
    peek_ind(6'o30, v); chk("R4 30 untouched", v, 0);
  endtask

  task automatic t_dec_wrap();
    logic [7:0] v;
    set_ptr(6'o41);
    acc(2'b11, 1, 4'd0, 8'h21);
    chk("R5 step", ptr_o, 6'o40);
    acc(2'b11, 1, 4'd0, 8'h22);
    chk("R5 wrap 40->47", ptr_o, 6'o47);
    peek_ind(6'o40, v); chk("R5 data at 40", v, 8'h22);
  endtask

  task automatic t_old_data();
    logic [7:0] v;
    set_ptr(6'o27);
    acc_en_i = 1; acc_we_i = 1; acc_mode_i = 2'b10; wdata_i = 8'h99; #1;
    chk("R8 old value", rdata_o, 8'h12);
    chk("R8 ptr before edge", ptr_o, 6'o27);
    tick(); idle();
    chk("R8 ptr after edge", ptr_o, 6'o20);
    peek_ind(6'o27, v); chk("R8 new value", v, 8'h99);
  endtask

  task automatic t_load_vs_step();
    set_ptr(6'o33);
    ptr_lo_ld_i = 1; ptr_imm_i = 3'd5; acc(2'b10, 0, 4'd0, 8'h00);
    chk("R7 lo load beats step", ptr_o, 6'o35);
    set_ptr(6'o33);
    ptr_hi_ld_i = 1; ptr_imm_i = 3'd6; acc(2'b10, 0, 4'd0, 8'h00);
    chk("R7 hi load with step", ptr_o, 6'o64);
  endtask

  task automatic t_save();
    logic [7:0] v;
    stat_save_i = 1; stat_i = 8'h5A; tick(); idle();
    chk("R9 slot", stat_slot_o, 8'h5A);
    peek_dir(4'd9, v); chk("R9 entry9", v, 8'h5A);
    acc(2'b00, 1, 4'd9, 8'h81);
    chk("R9 restore view", stat_slot_o, 8'h81);
  endtask

  task automatic t_save_prio();
    stat_save_i = 1; stat_i = 8'hC3;
    acc(2'b00, 1, 4'd9, 8'h18);
    chk("R10 save wins", stat_slot_o, 8'hC3);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    set_ptr(6'o13);
    acc_en_i = 0; acc_we_i = 1; acc_mode_i = 2'b10; wdata_i = 8'hFF; tick();
    acc_mode_i = 2'b00; acc_dir_i = 4'd4; tick(); idle();
    chk("R11 ptr", ptr_o, 6'o13);
    peek_dir(4'd4, v); chk("R11 entry4", v, 0);
    peek_ind(6'o13, v); chk("R11 entry13", v, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
    tick();
    t_reset();
    t_direct();
    t_alias();
    t_ptr_load();
    t_hold();
    t_inc_wrap();
    t_dec_wrap();
    t_old_data();
    t_load_vs_step();
    t_save();
    t_save_prio();
    t_disabled();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule